// File: doc/BRIEF.md
# Resistive Crossbar Look-up Table Access Controller

This block sequences every access to a small look-up table whose bits are stored as resistive cells at the crossings of a word-line / bit-line array. Each bit line reaches ground through its own column switch. The controller drives a two-bit level code on every word line, the column switch gates and the select of the output multiplexer. It takes an external comparator result as the sensed value of the addressed cell. The analog array, the comparator and the supplies are outside the block.

Two operations are offered. A programming request captures a full configuration word. The block then clears every cell column by column, and afterwards writes ones column by column into the cells whose configuration bit is set. A read request is addressed by the LUT inputs: the upper address bits pick the row and the lower bits pick the column. The block applies a short positive read pulse and captures the comparator result. When the result is zero, a negative restore pulse follows at once on the same row. All pulse lengths are parameters counted in clock cycles, with defaults chosen for a 125 MHz clock: 19 cycles for a write pulse (about 150 ns) and 2 cycles each for the read and restore pulses.

Top module: `lut_xbar_ctrl`

## Requirements
- R1: After reset and whenever the block is idle, busy and done are low, every word-line code is float, all column gates are off, the select is 0 and rd_data is 0 until the first read completes.
- R2: Word-line codes are 00 float, 01 positive, 10 negative and 11 ground, and row r occupies wl_code bits [2r+1:2r]. Address bits above the column field give the row, the low COL_BITS bits give the column, and configuration bit index equals the address value.
- R3: The first programming phase visits columns 0 to COLS-1 in order. For WRITE_CYC cycles per column, only that column's gate is on and every row is negative.
- R4: The second programming phase visits columns 0 to COLS-1 in order. For WRITE_CYC cycles per column, only that column's gate is on, rows whose configuration bit is 1 are positive and all other rows float.
- R5: busy rises after the accepting clock edge and stays high through the last pulse. Programming keeps it high for 2*COLS*WRITE_CYC cycles. done is high for exactly the one cycle after busy falls, and never together with busy.
- R6: During a read pulse of READ_CYC cycles, the addressed row is positive, every other row is ground, only the addressed column gate is on and the select equals the column index. Outside the read pulse the select is 0.
- R7: rd_data takes the comparator value sampled in the final read-pulse cycle and holds it at all other times.
- R8: When the sampled value is 0, a restore pulse of max(RESTORE_CYC, READ_CYC) cycles follows immediately: the addressed row is negative, other rows float and the addressed gate stays on. When the sampled value is 1, the block returns to idle with no restore pulse.
- R9: A cycle in which both enables are high while idle starts nothing: busy stays low and the stored cells are unchanged.
- R10: Requests that arrive while busy are ignored. They neither lengthen nor alter the running operation.
- R11: At most one column gate is on in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Programming request, sampled while idle |
| rd_en | input | 1 | Read request, sampled while idle |
| addr | input | ROW_BITS+COL_BITS | LUT input bits: row in the upper bits, column in the lower bits |
| cfg_data | input | ROWS*COLS | Configuration word captured with a programming request |
| sense_in | input | 1 | Digital comparator result for the addressed cell |
| wl_code | output | 2*ROWS | Per-row word-line level code |
| col_gate | output | COLS | Per-column ground switch gates |
| mux_sel | output | COL_BITS | Output multiplexer select |
| rd_data | output | 1 | Last sensed bit |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle strobe at the end of a read or a programming sequence |

## Verification
The bench models the array at the pins. A cell changes state only after a full write-length run of one polarity on its gated column. A controller that skipped the clearing phase, or shortened a write pulse, would therefore read back stale ones after reprogramming. Every address is read after two complementary configurations. Each zero read must show an exact restore window, and each one read must show none, so a design that restored after every read or sampled the comparator a cycle early is exposed. Requests raised with both enables high, or while a programming sequence runs, are checked by cycle counts and readback. A controller that accepted them would lengthen busy or corrupt the stored pattern.

// File: rtl/lut_xbar_pkg.sv
package lut_xbar_pkg;
  // Word-line level codes (R2)
  typedef enum logic [1:0] {
    WL_FLOAT = 2'b00,
    WL_POS   = 2'b01,
    WL_NEG   = 2'b10,
    WL_GND   = 2'b11
  } wl_code_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLR,
    ST_SET,
    ST_READ,
    ST_RESTORE
  } xbar_st_t;
endpackage

// File: rtl/lut_xbar_cfg.sv
module lut_xbar_cfg
  import lut_xbar_pkg::*;
#(
  parameter int CELLS = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CELLS-1:0] din,
  output logic [CELLS-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst) dout <= '0;
    else if (load) dout <= din;
  end
endmodule

// File: rtl/lut_xbar_seq.sv
module lut_xbar_seq
  import lut_xbar_pkg::*;
#(
  parameter int ROW_BITS    = 2,
  parameter int COL_BITS    = 2,
  parameter int WRITE_CYC   = 19,
  parameter int READ_CYC    = 2,
  parameter int RESTORE_CYC = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic                         rd_en,
  input  logic [ROW_BITS+COL_BITS-1:0] addr,
  input  logic                         sense_in,
  output xbar_st_t                     st,
  output logic [ROW_BITS-1:0]          row,
  output logic [COL_BITS-1:0]          col,
  output logic                         load_cfg,
  output logic                         rd_data,
  output logic                         done
);
  localparam int ADDR_W   = ROW_BITS + COL_BITS;
  localparam int COLS     = 1 << COL_BITS;
  localparam int REST_EFF = (RESTORE_CYC > READ_CYC) ? RESTORE_CYC : READ_CYC;
  localparam int MAX_A    = (WRITE_CYC > READ_CYC) ? WRITE_CYC : READ_CYC;
  localparam int CNT_MAX  = (MAX_A > REST_EFF) ? MAX_A : REST_EFF;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);

  logic [CNT_W-1:0] cnt;
  logic             wr_go;
  logic             rd_go;
  logic             last_col;

  assign wr_go    = (st == ST_IDLE) && wr_en && !rd_en;
  assign rd_go    = (st == ST_IDLE) && rd_en && !wr_en;
  assign load_cfg = wr_go;
  assign last_col = (col == COL_BITS'(COLS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      row     <= '0;
      col     <= '0;
      rd_data <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          cnt <= '0;
          if (wr_go) begin
            st  <= ST_CLR;
            col <= '0;
          end else if (rd_go) begin
            st  <= ST_READ;
            row <= addr[ADDR_W-1 -: ROW_BITS];
            col <= addr[COL_BITS-1:0];
          end
        end
        ST_CLR, ST_SET: begin
          if (cnt == CNT_W'(WRITE_CYC - 1)) begin
            cnt <= '0;
            if (last_col) begin
              col <= '0;
              if (st == ST_CLR) begin
                st <= ST_SET;
              end else begin
                st   <= ST_IDLE;
                done <= 1'b1;
              end
            end else begin
              col <= col + COL_BITS'(1);
            end
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_READ: begin
          if (cnt == CNT_W'(READ_CYC - 1)) begin
            cnt     <= '0;
            rd_data <= sense_in;
            if (sense_in) begin
              st   <= ST_IDLE;
              done <= 1'b1;
            end else begin
              st <= ST_RESTORE;
            end
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_RESTORE: begin
          if (cnt == CNT_W'(REST_EFF - 1)) begin
            cnt  <= '0;
            st   <= ST_IDLE;
            done <= 1'b1;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lut_xbar_drive.sv
module lut_xbar_drive
  import lut_xbar_pkg::*;
#(
  parameter int ROW_BITS = 2,
  parameter int COL_BITS = 2
) (
  input  xbar_st_t                                   st,
  input  logic [ROW_BITS-1:0]                        row,
  input  logic [COL_BITS-1:0]                        col,
  input  logic [(1<<ROW_BITS)*(1<<COL_BITS)-1:0]     cfg,
  output logic [2*(1<<ROW_BITS)-1:0]                 wl_code,
  output logic [(1<<COL_BITS)-1:0]                   col_gate,
  output logic [COL_BITS-1:0]                        mux_sel,
  output logic                                       busy
);
  localparam int ROWS = 1 << ROW_BITS;
  localparam int COLS = 1 << COL_BITS;

  assign busy    = (st != ST_IDLE);
  assign mux_sel = (st == ST_READ) ? col : '0;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    wl_code_t lvl;
    logic     hit;
    assign hit = (row == ROW_BITS'(r));
    always_comb begin
      unique case (st)
        ST_CLR:     lvl = WL_NEG;
        ST_SET:     lvl = cfg[{ROW_BITS'(r), col}] ? WL_POS : WL_FLOAT;
        ST_READ:    lvl = hit ? WL_POS : WL_GND;
        ST_RESTORE: lvl = hit ? WL_NEG : WL_FLOAT;
        default:    lvl = WL_FLOAT;
      endcase
    end
    assign wl_code[2*r +: 2] = lvl;
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    assign col_gate[c] = busy && (col == COL_BITS'(c));
  end
endmodule

// File: rtl/lut_xbar_ctrl.sv
module lut_xbar_ctrl
  import lut_xbar_pkg::*;
#(
  parameter int ROW_BITS    = 2,
  parameter int COL_BITS    = 2,
  parameter int WRITE_CYC   = 19,
  parameter int READ_CYC    = 2,
  parameter int RESTORE_CYC = 2
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   wr_en,
  input  logic                                   rd_en,
  input  logic [ROW_BITS+COL_BITS-1:0]           addr,
  input  logic [(1<<ROW_BITS)*(1<<COL_BITS)-1:0] cfg_data,
  input  logic                                   sense_in,
  output logic [2*(1<<ROW_BITS)-1:0]             wl_code,
  output logic [(1<<COL_BITS)-1:0]               col_gate,
  output logic [COL_BITS-1:0]                    mux_sel,
  output logic                                   rd_data,
  output logic                                   busy,
  output logic                                   done
);
  localparam int CELLS = (1 << ROW_BITS) * (1 << COL_BITS);

  xbar_st_t            st;
  logic [ROW_BITS-1:0] row;
  logic [COL_BITS-1:0] col;
  logic                load_cfg;
  logic [CELLS-1:0]    cfg_q;

  lut_xbar_seq #(
    .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .WRITE_CYC(WRITE_CYC),
    .READ_CYC(READ_CYC), .RESTORE_CYC(RESTORE_CYC)
  ) u_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .sense_in(sense_in), .st(st), .row(row), .col(col),
    .load_cfg(load_cfg), .rd_data(rd_data), .done(done)
  );

  lut_xbar_cfg #(.CELLS(CELLS)) u_cfg (
    .clk(clk), .rst(rst), .load(load_cfg), .din(cfg_data), .dout(cfg_q)
  );

  lut_xbar_drive #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_drv (
    .st(st), .row(row), .col(col), .cfg(cfg_q), .wl_code(wl_code),
    .col_gate(col_gate), .mux_sel(mux_sel), .busy(busy)
  );
endmodule

// File: rtl/lut_xbar_ctrl_chk.sv
module lut_xbar_ctrl_chk
  import lut_xbar_pkg::*;
#(
  parameter int ROW_BITS = 2,
  parameter int COL_BITS = 2
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       wr_en,
  input logic                       rd_en,
  input logic [2*(1<<ROW_BITS)-1:0] wl_code,
  input logic [(1<<COL_BITS)-1:0]   col_gate,
  input logic [COL_BITS-1:0]        mux_sel,
  input logic                       rd_data,
  input logic                       busy,
  input logic                       done
);
  localparam int ROWS = 1 << ROW_BITS;

  logic rd_act;
  logic neg_any;

  always_comb begin
    rd_act  = 1'b0;
    neg_any = 1'b0;
    for (int r = 0; r < ROWS; r++) begin
      if (wl_code[2*r +: 2] == WL_GND) rd_act = 1'b1;
      if (wl_code[2*r +: 2] == WL_NEG) neg_any = 1'b1;
    end
  end

  AST_ONE_GATE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(col_gate)); // R11
  AST_BOTH_EN_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!busy && wr_en && rd_en) |=> !busy); // R9
  AST_IDLE_FLOAT: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (col_gate == '0 && wl_code == '0)); // R1
  AST_SEL_OUTSIDE_READ: assert property (@(posedge clk) disable iff (rst)
    !rd_act |-> (mux_sel == '0)); // R6
  AST_RESTORE_ON_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($fell(rd_act) && !rd_data) |-> (busy && neg_any)); // R8
  AST_NO_RESTORE_ON_ONE: assert property (@(posedge clk) disable iff (rst)
    ($fell(rd_act) && rd_data) |-> (!busy && done)); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R5
endmodule

bind lut_xbar_ctrl lut_xbar_ctrl_chk #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .wl_code(wl_code),
  .col_gate(col_gate), .mux_sel(mux_sel), .rd_data(rd_data), .busy(busy),
  .done(done)
);

// File: tb/sim_lut_xbar_ctrl.sv
module sim_lut_xbar_ctrl;
  localparam int RB    = 2;
  localparam int CB    = 2;
  localparam int ROWS  = 1 << RB;
  localparam int COLS  = 1 << CB;
  localparam int CELLS = ROWS * COLS;
  localparam int WC    = 19;
  localparam int RC    = 2;
  localparam int RS    = 2;
  localparam int REFF  = (RS > RC) ? RS : RC;
  localparam int PROG  = 2 * COLS * WC;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic rd_en = 1'b0;
  logic [RB+CB-1:0] addr = '0;
  logic [CELLS-1:0] cfg_data = '0;
  logic sense_in;
  logic [2*ROWS-1:0] wl_code;
  logic [COLS-1:0] col_gate;
  logic [CB-1:0] mux_sel;
  logic rd_data, busy, done;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  lut_xbar_ctrl #(.ROW_BITS(RB), .COL_BITS(CB), .WRITE_CYC(WC),
                  .READ_CYC(RC), .RESTORE_CYC(RS)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .cfg_data(cfg_data), .sense_in(sense_in), .wl_code(wl_code),
    .col_gate(col_gate), .mux_sel(mux_sel), .rd_data(rd_data),
    .busy(busy), .done(done)
  );

  // Pin-level array model: a cell flips only after a full write-length run.
  logic mcell [ROWS][COLS];
  int   prun  [ROWS][COLS];
  int   nrun  [ROWS][COLS];

  initial begin
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        mcell[r][c] = 1'b0; prun[r][c] = 0; nrun[r][c] = 0;
      end
  end

  always @(posedge clk) begin
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        if (col_gate[c] && wl_code[2*r +: 2] == 2'b01) begin
          prun[r][c] <= prun[r][c] + 1; nrun[r][c] <= 0;
          if (prun[r][c] + 1 >= WC) mcell[r][c] <= 1'b1;
        end else if (col_gate[c] && wl_code[2*r +: 2] == 2'b10) begin
          nrun[r][c] <= nrun[r][c] + 1; prun[r][c] <= 0;
          if (nrun[r][c] + 1 >= WC) mcell[r][c] <= 1'b0;
        end else begin
          prun[r][c] <= 0; nrun[r][c] <= 0;
        end
      end
  end

  always_comb begin
    logic gnd_seen;
    gnd_seen = 1'b0;
    sense_in = 1'b0;
    for (int r = 0; r < ROWS; r++)
      if (wl_code[2*r +: 2] == 2'b11) gnd_seen = 1'b1;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        if (gnd_seen && col_gate[c] && wl_code[2*r +: 2] == 2'b01)
          sense_in = mcell[r][c];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(wl_code == '0, "R1 wl_code", wl_code, 0);
    chk(col_gate == '0, "R1 col_gate", col_gate, 0);
    chk(mux_sel == '0 && rd_data == 1'b0, "R1 sel/rd_data", {mux_sel, rd_data}, 0);
  endtask

  // inject: raise other requests mid-sequence (R10)
  task automatic t_program(input logic [CELLS-1:0] pat, input bit inject);
    int k, bad3, bad4;
    k = 0; bad3 = 0; bad4 = 0;
    @(negedge clk); wr_en = 1'b1; cfg_data = pat;
    @(posedge clk);
    @(negedge clk); wr_en = 1'b0; cfg_data = ~pat;
    while (busy && k < 10000) begin
      int ph, c;
      ph = k / (COLS * WC);
      c  = (k / WC) % COLS;
      for (int r = 0; r < ROWS; r++) begin
        logic [1:0] e;
        if (ph == 0) e = 2'b10;
        else e = pat[r*COLS + c] ? 2'b01 : 2'b00;
        if (wl_code[2*r +: 2] != e) begin
          if (ph == 0) bad3++; else bad4++;
        end
      end
      if (col_gate != COLS'(1 << c)) begin
        if (ph == 0) bad3++; else bad4++;
      end
      if (done) bad4++;
      k++;
      if (inject && k == 40) begin rd_en = 1'b1; addr = '0; end
      if (inject && k == 41) rd_en = 1'b0;
      if (inject && k == 80) wr_en = 1'b1;
      if (inject && k == 81) wr_en = 1'b0;
      @(negedge clk);
    end
    chk(bad3 == 0, "R3 clear phase drive", bad3, 0);
    chk(bad4 == 0, "R4 set phase drive", bad4, 0);
    chk(k == PROG, inject ? "R10 busy length with requests" : "R5 program busy length", k, PROG);
    chk(done == 1'b1, "R5 done after program", done, 1);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R10 no extra operation", {busy, done}, 0);
  endtask

  task automatic t_read(input int a, input bit exp);
    int k, bad6, bad8, r, c;
    k = 0; bad6 = 0; bad8 = 0;
    r = a / COLS; c = a % COLS;
    @(negedge clk); rd_en = 1'b1; addr = (RB+CB)'(a);
    @(posedge clk);
    @(negedge clk); rd_en = 1'b0; addr = ~addr;
    while (busy && k < 100) begin
      for (int q = 0; q < ROWS; q++) begin
        logic [1:0] e;
        if (k < RC) e = (q == r) ? 2'b01 : 2'b11;
        else e = (q == r) ? 2'b10 : 2'b00;
        if (wl_code[2*q +: 2] != e) begin
          if (k < RC) bad6++; else bad8++;
        end
      end
      if (col_gate != COLS'(1 << c)) begin
        if (k < RC) bad6++; else bad8++;
      end
      if (k < RC && mux_sel != CB'(c)) bad6++;
      if (k >= RC && mux_sel != '0) bad8++;
      k++;
      @(negedge clk);
    end
    chk(bad6 == 0, "R6 read pulse drive", bad6, 0);
    chk(bad8 == 0, "R8 restore drive", bad8, 0);
    chk(k == (exp ? RC : RC + REFF), "R8 read/restore length", k, exp ? RC : RC + REFF);
    chk(rd_data == exp, "R7 sensed bit", rd_data, exp);
    chk(done == 1'b1, "R5 done after read", done, 1);
  endtask

  task automatic t_read_all(input logic [CELLS-1:0] pat);
    for (int a = 0; a < CELLS; a++) t_read(a, pat[a]);
  endtask

  task automatic t_both(input logic [CELLS-1:0] held, input int a);
    int bad;
    bad = 0;
    @(negedge clk); wr_en = 1'b1; rd_en = 1'b1; cfg_data = ~held; addr = '0;
    @(posedge clk);
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (busy || done || wl_code != '0) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R9 both enables start nothing", bad, 0);
    t_read(a, held[a]); // R9 stored cell unchanged
  endtask

  localparam logic [CELLS-1:0] PAT_A = 16'hA5C3;
  localparam logic [CELLS-1:0] PAT_B = 16'h5A3C;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_program(PAT_A, 1'b0);
    t_read_all(PAT_A);
    t_both(PAT_A, 0);
    t_program(PAT_B, 1'b1);
    t_read_all(PAT_B);
    t_read(5, PAT_B[5]);
    t_read(5, PAT_B[5]);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule